// File: doc/BRIEF.md
# Serial Command Port with Chain Pass-Through

This block is a synchronous serial slave with a word width of sixteen bits. It sits between an external serial master and the command and status logic of a driver chip. While its chip-select input is held low, it receives a command word one bit at a time. At the same time it sends out a status word, least significant bit first in both directions.

All three serial inputs are first brought into the system clock domain through a flop chain, and edges are detected after that. When chip select falls, the block copies a snapshot of the parallel status word into its shift register. Each falling serial clock edge samples one data bit. Each rising serial clock edge moves the next bit onto the output. The received word is copied into the control register only when chip select rises.

Bits keep flowing through the shift register for as long as clocks arrive. As a result, the output of one device can feed the input of the next, and a transfer longer than one word passes bits straight through the chain. The data output has an enable that is asserted only while the device is selected, so several devices can share one return line.

Top module: `serial_cmd_port`

## Requirements
- R1: `sdo_oe_o` is high only while the synchronised chip select is low; at all other times it is low, and the pad driver it controls floats the line.
- R2: After reset, `ctrl_o` equals 16'hE000: bits 15, 14 and 13 are high and bits 12 to 0 are low.
- R3: While the device is selected, each falling serial clock edge shifts `sdi_i` in at bit 15 of the shift register. All other bits move one place toward bit 0, so the first bit received ends at bit 0.
- R4: `sdo_o` changes only on a rising serial clock edge while selected, where it takes shift-register bit 0, or on the falling edge of chip select. It holds its value between those events.
- R5: When chip select falls, `status_i` is captured and its bit 0 appears on `sdo_o` before the first serial clock edge.
- R6: `ctrl_o` changes only on the rising edge of chip select, where it takes the whole shift register.
- R7: If a transfer has fewer or more than 16 falling clock edges, the control register takes the last 16 bits shifted in. When fewer than 16 bits arrived, the top status bits that have not yet been shifted out fill the remaining positions.
- R8: Output bit number k of a transfer, for k from 16 upward, equals input bit number k-16 of the same transfer. This is the chain pass-through.
- R9: Serial clock and data activity while chip select is high changes neither `ctrl_o` nor the next status snapshot.
- R10: Changes on `status_i` after chip select has fallen do not reach `sdo_o` during that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select from the serial master, active low |
| sck_i | input | 1 | Serial clock from the master |
| sdi_i | input | 1 | Serial data input |
| status_i | input | 16 | Parallel status word to be sent |
| sdo_o | output | 1 | Serial data output |
| sdo_oe_o | output | 1 | Output enable for the serial data pad |
| ctrl_o | output | 16 | Control register applied at chip-select release |

## Verification
The assertions assume that the serial inputs change slowly enough, relative to the system clock, that every level lasts longer than the synchroniser depth. They also assume that `sdi_i` is stable around each falling serial clock edge, so that the synchronised data bit and the synchronised clock edge belong together. The stimulus holds each serial clock half-period and each chip-select setup for eight system clocks. It changes data only just before a rising edge. The bench sweeps transfer lengths from 0 to 40 bits, so it covers short words, exact words and chained transfers.

// File: rtl/scp_pkg.sv
package scp_pkg;
   parameter int unsigned SCP_WORD_W = 16;
   parameter int unsigned SCP_SYNC_STAGES = 2;

   typedef struct packed {
      logic lvl;
      logic rise;
      logic fall;
   } scp_edge_t;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("scp_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/scp_edge.sv
module scp_edge
   import scp_pkg::*;
#(
   parameter logic RST_LVL = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      d,
   output scp_edge_t e
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_LVL;
      else        prev_q <= d;
   end

   assign e.lvl  = d;
   assign e.rise = d & ~prev_q;
   assign e.fall = ~d & prev_q;
endmodule

// File: rtl/scp_shift.sv
module scp_shift #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         shift_en,
   input  logic         adv,
   input  logic         sdi,
   input  logic [W-1:0] par_i,
   output logic [W-1:0] par_o,
   output logic         sdo
);
   if (W < 2) begin : g_bad_w
      $error("scp_shift: W must be at least 2");
   end

   logic [W-1:0] sr_q;
   logic         out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q  <= '0;
         out_q <= 1'b0;
      end else if (load) begin
         sr_q  <= par_i;
         out_q <= par_i[0];
      end else begin
         if (shift_en) sr_q  <= {sdi, sr_q[W-1:1]};
         if (adv)      out_q <= sr_q[0];
      end
   end

   assign par_o = sr_q;
   assign sdo   = out_q;

   p_shift_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !load) |=> (sr_q[W-1] == $past(sdi)));

   p_snapshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> ((sr_q == $past(par_i)) && (out_q == $past(par_i[0]))));

   p_out_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv) |=> $stable(out_q));
endmodule

// File: rtl/scp_ctrl_reg.sv
module scp_ctrl_reg #(
   parameter int unsigned  W       = 16,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         upd,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] reg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   reg_q <= RST_VAL;
      else if (upd) reg_q <= d;
   end

   assign q = reg_q;

   p_ctrl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(reg_q));

   p_ctrl_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> (reg_q == $past(d)));
endmodule

// File: rtl/serial_cmd_port.sv
module serial_cmd_port
   import scp_pkg::*;
#(
   parameter int unsigned WORD_W      = SCP_WORD_W,
   parameter int unsigned SYNC_STAGES = SCP_SYNC_STAGES,
   parameter logic [WORD_W-1:0] CTRL_RST = 16'hE000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_i,
   input  logic              sck_i,
   input  logic              sdi_i,
   input  logic [WORD_W-1:0] status_i,
   output logic              sdo_o,
   output logic              sdo_oe_o,
   output logic [WORD_W-1:0] ctrl_o
);
   localparam int unsigned NSIG = 3;
   localparam logic [NSIG-1:0] SYNC_RST = 3'b100;

   if (WORD_W < 2) begin : g_bad_word
      $error("serial_cmd_port: WORD_W must be at least 2");
   end

   logic [NSIG-1:0] raw_in;
   logic [NSIG-1:0] syn;
   scp_edge_t       cs_e;
   scp_edge_t       sck_e;
   logic            selected;
   logic [WORD_W-1:0] sr_par;

   assign raw_in = {cs_n_i, sck_i, sdi_i};

   scp_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
   );

   scp_edge #(.RST_LVL(1'b1)) u_cs_edge (
      .clk(clk), .rst_n(rst_n), .d(syn[2]), .e(cs_e)
   );

   scp_edge #(.RST_LVL(1'b0)) u_sck_edge (
      .clk(clk), .rst_n(rst_n), .d(syn[1]), .e(sck_e)
   );

   assign selected = ~cs_e.lvl;

   scp_shift #(.W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .load(cs_e.fall),
      .shift_en(sck_e.fall & selected),
      .adv(sck_e.rise & selected),
      .sdi(syn[0]),
      .par_i(status_i),
      .par_o(sr_par),
      .sdo(sdo_o)
   );

   scp_ctrl_reg #(.W(WORD_W), .RST_VAL(CTRL_RST)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .upd(cs_e.rise),
      .d(sr_par),
      .q(ctrl_o)
   );

   assign sdo_oe_o = selected;

   p_ctrl_at_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_o != $past(ctrl_o)) |-> $past(cs_e.rise));

   p_quiet_deselected_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_e.lvl && !cs_e.rise && !cs_e.fall) |=> $stable(sdo_o));
endmodule

// File: tb/serial_cmd_port_tb.sv
module serial_cmd_port_tb;
   localparam int W = 16;
   localparam int H = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cs_n = 1'b1;
   logic         sck = 1'b0;
   logic         sdi = 1'b0;
   logic [W-1:0] status = '0;
   logic         sdo;
   logic         sdo_oe;
   logic [W-1:0] ctrl;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   serial_cmd_port u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .sdi_i(sdi),
      .status_i(status), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .ctrl_o(ctrl)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic stream(input logic [W-1:0] st, input logic [63:0] data,
                                   input int k);
      if (k < W) return st[k];
      return data[k-W];
   endfunction

   // One transfer of n bits; status changes mid-transfer (R10).
   task automatic xfer(input int n, input logic [63:0] data, input logic [W-1:0] st);
      logic [W-1:0] exp_ctrl;
      status = st;
      idle(2);
      cs_n = 1'b0;
      idle(H);
      chk(sdo_oe === 1'b1, "R1 oe while selected", sdo_oe, 1);
      chk(sdo === st[0], "R5 bit0 before clocks", sdo, st[0]);
      status = ~st;
      for (int j = 0; j < n; j++) begin
         sdi = data[j];
         idle(H);
         sck = 1'b1;
         idle(H);
         if (j >= W)
            chk(sdo === data[j-W], "R8 pass-through bit", sdo, data[j-W]);
         else
            chk(sdo === st[j], "R3 R4 R10 status bit", sdo, st[j]);
         sck = 1'b0;
         idle(H);
      end
      chk(ctrl === u_ctrl_prev, "R6 ctrl held during transfer", ctrl, u_ctrl_prev);
      cs_n = 1'b1;
      idle(H);
      for (int i = 0; i < W; i++) exp_ctrl[i] = stream(st, data, n + i);
      chk(ctrl === exp_ctrl, "R7 R6 ctrl after release", ctrl, exp_ctrl);
      chk(sdo_oe === 1'b0, "R1 oe after release", sdo_oe, 0);
      u_ctrl_prev = exp_ctrl;
   endtask

   logic [W-1:0] u_ctrl_prev;

   initial begin
      u_ctrl_prev = 16'hE000;
      idle(3);
      rst_n = 1'b1;
      idle(4);
      chk(ctrl === 16'hE000, "R2 reset value", ctrl, 16'hE000);
      chk(sdo_oe === 1'b0, "R1 oe at reset", sdo_oe, 0);

      for (int n = 0; n <= 40; n++) begin
         logic [63:0] d;
         logic [W-1:0] st;
         d  = (64'h0123_4567_89AB_CDEF * (n + 3)) ^ {n[15:0], 48'h5A5A_C3C3_0F0F};
         st = 16'h1357 + 16'h0F1F * n[15:0];
         xfer(n, d, st);
         if (n % 7 == 3) begin
            // R9: toggle clock and data while deselected.
            for (int t = 0; t < 5; t++) begin
               sdi = t[0];
               sck = 1'b1; idle(H);
               sck = 1'b0; idle(H);
            end
            chk(ctrl === u_ctrl_prev, "R9 ctrl unchanged", ctrl, u_ctrl_prev);
            chk(sdo_oe === 1'b0, "R9 oe stays low", sdo_oe, 0);
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule